// File: doc/BRIEF.md
# CAN identifier acceptance filter bank

This block decides whether a received CAN frame may enter the receive FIFO. It compares the frame identifier with a bank of programmable filter elements. Each element is a value and mask pair. Two count fields split the bank into two regions. The first region holds extended-identifier elements and the second holds standard-identifier elements. The frame's IDE bit selects which region is scanned, so an element does not store a frame-type bit of its own.

A scan starts from a one-cycle frame strobe. Elements are visited one per clock in ascending order, and the scan stops at the first hit. The result is a one-cycle `dec_done` pulse with an accept flag and the index of the element that hit. A frame that arrives while the block is busy is parked in a single holding slot. Configuration writes that arrive while the block is busy are queued and applied after the decision, so the frame being scanned always sees one consistent bank.

Control is a three-state machine:
- `S_IDLE` waits. It goes to `S_DRAIN` when the write queue holds entries. It goes to `S_SCAN` when a frame starts and its region is not empty. It stays in `S_IDLE` and rejects at once when the region is empty.
- `S_SCAN` compares one element per cycle. It returns to `S_IDLE` on a hit or after the last element of the region.
- `S_DRAIN` commits one queued write per cycle and returns to `S_IDLE` once the queue is empty.

Top module: `canid_accept_bank`

## Requirements
- R1: After `rst` (synchronous, active high), `dec_done`, `dec_accept` and `dec_index` are 0. Both counts are 0 (one element in use, no extended elements). Every element value and mask is 0.
- R2: With E = min(NEXIF, NFE+1), a frame with `frm_ide`=1 scans only indices 0..E-1, and a frame with `frm_ide`=0 scans only indices E..NFE. Elements outside the selected region never cause acceptance.
- R3: For `frm_ide`=0 only identifier bits 28..18 are compared. Bits 17..0 of the identifier, value and mask have no effect.
- R4: For `frm_ide`=1 all 29 identifier bits are compared.
- R5: An element hits when ((id XOR value) AND mask) is zero over the active bits. A mask bit of 1 means the bit is compared and 0 means it is ignored. The frame is accepted if any element in its region hits, and `dec_index` reports the lowest such index.
- R6: When the selected region is empty, `dec_done` rises with `dec_accept`=0 after the clock edge that takes the strobe, and no scan is made.
- R7: If the strobe is taken at edge t, a hit at region offset j raises `dec_done` after edge t+1+j. A reject from a region of C elements raises `dec_done` after edge t+C.
- R8: A strobe that arrives while the block is busy is held with its identifier and IDE. It is scanned when the block returns to idle. Only one frame is held, and further strobes arriving while the slot is full are dropped.
- R9: Writes that arrive while a frame is being started or scanned, or while queued writes are still pending, do not affect that frame. Up to WQ_DEPTH such writes are applied in arrival order before the next frame starts, and any further ones are dropped.
- R10: `dec_accept` and `dec_index` are 0 whenever `dec_done` is 0. A reject reports index 0.
- R11: When NEXIF exceeds NFE+1, all NFE+1 elements belong to the extended region and the standard region is empty.
- R12: Write-port encoding:
  - `wr_kind` 0 writes an element value from `wr_data[28:0]`.
  - `wr_kind` 1 writes an element mask from `wr_data[28:0]`.
  - `wr_kind` 2 writes both counts: NFE from `wr_data[7:0]` and NEXIF from `wr_data[31:24]`.
  - `wr_kind` 3, and any `wr_idx` of N_ELEM or above, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_vld | input | 1 | One-cycle strobe: a received frame identifier is present |
| frm_id | input | 29 | Frame identifier; a standard identifier sits in bits 28..18 |
| frm_ide | input | 1 | 1 = extended frame, 0 = standard frame |
| wr_en | input | 1 | Write strobe for the element bank and counts |
| wr_kind | input | 2 | 0 value, 1 mask, 2 counts, 3 no operation |
| wr_idx | input | 8 | Element index for value and mask writes |
| wr_data | input | 32 | Write data |
| dec_done | output | 1 | One-cycle pulse: decision ready |
| dec_accept | output | 1 | 1 = frame accepted |
| dec_index | output | $clog2(N_ELEM) | Index of the first element that hit |

## Verification
The bench builds the block with N_ELEM=8 and WQ_DEPTH=2. With that bank size, six elements in use leave two unused elements with an all-zero mask that would match anything, so any leak past NFE shows up as a false accept. Regions are short enough to check the exact cycle of every decision. The shallow queue lets three writes during one three-element scan overflow it, so both the in-order commit and the drop of the excess can be observed through later frame results.

// File: rtl/canid_pkg.sv
package canid_pkg;

    localparam int ID_W      = 29;
    localparam int STD_W     = 11;
    localparam int WD_W      = 32;
    localparam int WIDX_W    = 8;
    localparam int NFE_LSB   = 0;
    localparam int NEXIF_LSB = 24;

    typedef enum logic [1:0] {
        WK_VALUE = 2'd0,
        WK_MASK  = 2'd1,
        WK_COUNT = 2'd2,
        WK_NONE  = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_DRAIN = 2'd2
    } scan_state_e;

    typedef struct packed {
        wr_kind_e            kind;
        logic [WIDX_W-1:0]   idx;
        logic [WD_W-1:0]     data;
    } wr_rec_t;

endpackage

// File: rtl/cid_wr_queue.sv
module cid_wr_queue
    import canid_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  wr_rec_t push_rec,
    input  logic    pop,
    output wr_rec_t head,
    output logic    empty,
    output logic    full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wr_rec_t         slot [DEPTH];
    logic [PW-1:0]   wp;
    logic [PW-1:0]   rp;
    logic [CW-1:0]   cnt;
    logic            do_push;
    logic            do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot[wp] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/cid_elem_bank.sv
module cid_elem_bank
    import canid_pkg::*;
#(
    parameter int N_ELEM = 128,
    localparam int IDX_W = $clog2(N_ELEM),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  wr_rec_t           rec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ID_W-1:0]   rd_val,
    output logic [ID_W-1:0]   rd_msk,
    output logic [IDX_W-1:0]  cfg_nfe,
    output logic [CNT_W-1:0]  cfg_nexif
);
    logic [ID_W-1:0] val_q [N_ELEM];
    logic [ID_W-1:0] msk_q [N_ELEM];

    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        logic sel;
        assign sel = we && (rec.idx == WIDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[g] <= '0;
                msk_q[g] <= '0;
            end else if (sel) begin
                if (rec.kind == WK_VALUE) val_q[g] <= rec.data[ID_W-1:0];
                if (rec.kind == WK_MASK)  msk_q[g] <= rec.data[ID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_nfe   <= '0;
            cfg_nexif <= '0;
        end else if (we && rec.kind == WK_COUNT) begin
            cfg_nfe   <= rec.data[NFE_LSB +: IDX_W];
            cfg_nexif <= rec.data[NEXIF_LSB +: CNT_W];
        end
    end

    assign rd_val = val_q[rd_idx];
    assign rd_msk = msk_q[rd_idx];

endmodule

// File: rtl/cid_id_match.sv
module cid_id_match
    import canid_pkg::*;
(
    input  logic [ID_W-1:0] id,
    input  logic            ide,
    input  logic [ID_W-1:0] val,
    input  logic [ID_W-1:0] msk,
    output logic            hit
);
    logic [ID_W-1:0] diff;

    always_comb begin
        diff = (id ^ val) & msk;
        if (ide) begin
            hit = (diff == '0);
        end else begin
            hit = (diff[ID_W-1 -: STD_W] == '0);
        end
    end

endmodule

// File: rtl/canid_accept_bank.sv
module canid_accept_bank
    import canid_pkg::*;
#(
    parameter int N_ELEM   = 128,
    parameter int WQ_DEPTH = 4,
    localparam int IDX_W   = $clog2(N_ELEM),
    localparam int CNT_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_vld,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WD_W-1:0]   wr_data,
    output logic              dec_done,
    output logic              dec_accept,
    output logic [IDX_W-1:0]  dec_index
);
    scan_state_e       state;
    scan_state_e       nxt;

    // parked frame
    logic              hold_vld;
    logic [ID_W-1:0]   hold_id;
    logic              hold_ide;

    // frame under decision
    logic [ID_W-1:0]   cur_id;
    logic              cur_ide;
    logic [IDX_W-1:0]  ptr;
    logic [IDX_W-1:0]  cur_first;
    logic [IDX_W-1:0]  cur_last;

    // frame source and region of the frame about to start
    logic              start;
    logic [ID_W-1:0]   src_id;
    logic              src_ide;
    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  ext_cnt;
    logic [CNT_W-1:0]  rg_first_w;
    logic [CNT_W-1:0]  rg_cnt;
    logic [CNT_W-1:0]  rg_last_w;
    logic              reg_empty;

    // bank and queue
    logic [ID_W-1:0]   rd_val;
    logic [ID_W-1:0]   rd_msk;
    logic [IDX_W-1:0]  cfg_nfe;
    logic [CNT_W-1:0]  cfg_nexif;
    logic              hit;
    wr_rec_t           port_rec;
    wr_rec_t           q_head;
    wr_rec_t           bank_rec;
    logic              q_empty;
    logic              q_full;
    logic              q_push;
    logic              q_pop;
    logic              direct_we;
    logic              bank_we;

    // ---------------- frame source selection ----------------
    assign start   = (state == S_IDLE) && q_empty && (hold_vld || frm_vld);
    assign src_id  = hold_vld ? hold_id  : frm_id;
    assign src_ide = hold_vld ? hold_ide : frm_ide;

    // ---------------- region of the selected frame ----------------
    always_comb begin
        total      = CNT_W'(cfg_nfe) + CNT_W'(1);
        ext_cnt    = (cfg_nexif > total) ? total : cfg_nexif;
        rg_first_w = src_ide ? '0 : ext_cnt;
        rg_cnt     = src_ide ? ext_cnt : (total - ext_cnt);
        reg_empty  = (rg_cnt == '0);
        rg_last_w  = rg_first_w + rg_cnt - CNT_W'(1);
    end

    // ---------------- write routing ----------------
    assign port_rec  = '{kind: wr_kind_e'(wr_kind), idx: wr_idx, data: wr_data};
    assign direct_we = wr_en && (state == S_IDLE) && q_empty && !start;
    assign q_push    = wr_en && !direct_we;
    assign q_pop     = (state == S_DRAIN) && !q_empty;
    assign bank_we   = direct_we || q_pop;
    assign bank_rec  = q_pop ? q_head : port_rec;

    cid_wr_queue #(
        .DEPTH    (WQ_DEPTH)
    ) u_wq (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_rec (port_rec),
        .pop      (q_pop),
        .head     (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    cid_elem_bank #(
        .N_ELEM    (N_ELEM)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .we        (bank_we),
        .rec       (bank_rec),
        .rd_idx    (ptr),
        .rd_val    (rd_val),
        .rd_msk    (rd_msk),
        .cfg_nfe   (cfg_nfe),
        .cfg_nexif (cfg_nexif)
    );

    cid_id_match u_match (
        .id  (cur_id),
        .ide (cur_ide),
        .val (rd_val),
        .msk (rd_msk),
        .hit (hit)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // ---------------- transitions ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (!q_empty)                 nxt = S_DRAIN;
                else if (start && !reg_empty) nxt = S_SCAN;
            end
            S_SCAN: begin
                if (hit || (ptr == cur_last)) nxt = S_IDLE;
            end
            S_DRAIN: begin
                if (q_empty)                  nxt = S_IDLE;
            end
            default:                          nxt = S_IDLE;
        endcase
    end

    // ---------------- outputs and scan datapath ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_done   <= 1'b0;
            dec_accept <= 1'b0;
            dec_index  <= '0;
            ptr        <= '0;
            cur_first  <= '0;
            cur_last   <= '0;
            cur_id     <= '0;
            cur_ide    <= 1'b0;
        end else begin
            dec_done   <= 1'b0;
            dec_accept <= 1'b0;
            dec_index  <= '0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        cur_id    <= src_id;
                        cur_ide   <= src_ide;
                        ptr       <= IDX_W'(rg_first_w);
                        cur_first <= IDX_W'(rg_first_w);
                        cur_last  <= IDX_W'(rg_last_w);
                        if (reg_empty) dec_done <= 1'b1;
                    end
                end
                S_SCAN: begin
                    if (hit) begin
                        dec_done   <= 1'b1;
                        dec_accept <= 1'b1;
                        dec_index  <= ptr;
                    end else if (ptr == cur_last) begin
                        dec_done   <= 1'b1;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                S_DRAIN: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- single-slot frame hold ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_id  <= '0;
            hold_ide <= 1'b0;
        end else begin
            if (start && hold_vld) hold_vld <= 1'b0;
            // slot free now, or freed by this start while the input is not consumed
            if (frm_vld && (hold_vld == start)) begin
                hold_vld <= 1'b1;
                hold_id  <= frm_id;
                hold_ide <= frm_ide;
            end
        end
    end

endmodule

// File: rtl/canid_accept_bank_chk.sv
module canid_accept_bank_chk
    import canid_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_done,
    input logic             dec_accept,
    input logic [IDX_W-1:0] dec_index,
    input scan_state_e      state,
    input scan_state_e      nxt,
    input logic [IDX_W-1:0] ptr,
    input logic [IDX_W-1:0] cur_first,
    input logic [IDX_W-1:0] cur_last,
    input logic             hit,
    input logic             start,
    input logic             reg_empty,
    input logic             hold_vld,
    input logic [IDX_W-1:0] cfg_nfe,
    input logic [CNT_W-1:0] cfg_nexif
);

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dec_done && state == S_IDLE));

    p_region_bounds_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_done && dec_accept) |-> (dec_index >= cur_first && dec_index <= cur_last));

    p_accept_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_done && dec_accept) |-> $past(hit));

    p_empty_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (start && reg_empty) |=> (dec_done && !dec_accept));

    p_scan_step_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_SCAN && nxt == S_SCAN) |=> (state == S_SCAN && ptr == $past(ptr) + IDX_W'(1)));

    p_hold_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && state != S_IDLE) |=> hold_vld);

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_SCAN) |=> ($stable(cfg_nfe) && $stable(cfg_nexif)));

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !dec_done |-> (!dec_accept && dec_index == '0));

endmodule

bind canid_accept_bank canid_accept_bank_chk #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dec_done   (dec_done),
    .dec_accept (dec_accept),
    .dec_index  (dec_index),
    .state      (state),
    .nxt        (nxt),
    .ptr        (ptr),
    .cur_first  (cur_first),
    .cur_last   (cur_last),
    .hit        (hit),
    .start      (start),
    .reg_empty  (reg_empty),
    .hold_vld   (hold_vld),
    .cfg_nfe    (cfg_nfe),
    .cfg_nexif  (cfg_nexif)
);

// File: tb/canid_accept_bank_tb.sv
module canid_accept_bank_tb;
    localparam int NE = 8;
    localparam int IW = $clog2(NE);

    logic          clk = 1'b0;
    logic          rst;
    logic          frm_vld;
    logic [28:0]   frm_id;
    logic          frm_ide;
    logic          wr_en;
    logic [1:0]    wr_kind;
    logic [7:0]    wr_idx;
    logic [31:0]   wr_data;
    logic          dec_done;
    logic          dec_accept;
    logic [IW-1:0] dec_index;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int s_cyc = 0;
    int n_done = 0;
    int r_acc [8];
    int r_idx [8];
    int r_cyc [8];

    canid_accept_bank #(.N_ELEM(NE), .WQ_DEPTH(2)) u_dut (
        .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_id(frm_id), .frm_ide(frm_ide),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .dec_done(dec_done), .dec_accept(dec_accept), .dec_index(dec_index)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (dec_done) begin
            r_acc[n_done % 8] = int'(dec_accept);
            r_idx[n_done % 8] = int'(dec_index);
            r_cyc[n_done % 8] = cyc;
            n_done = n_done + 1;
        end
    end

    // {ide, id, accept, index, latency in edges after the strobe edge}
    typedef struct packed {
        logic        ide;
        logic [28:0] id;
        logic        acc;
        logic [2:0]  idx;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{1'b1, 29'h1234567,  1'b1, 3'd0, 4'd1},   // R4 exact extended
        '{1'b1, 29'h1234566,  1'b0, 3'd0, 4'd3},   // R4 one low bit differs
        '{1'b1, 29'h0ABCFFF,  1'b1, 3'd1, 4'd2},   // R5 masked-off bits ignored
        '{1'b1, 29'h00000FF,  1'b1, 3'd2, 4'd3},   // R7 last extended element
        '{1'b0, 29'h048EAAAA, 1'b1, 3'd3, 4'd1},   // R3 low 18 bits ignored
        '{1'b0, 29'h12AC0000, 1'b1, 3'd4, 4'd2},   // R3 partial mask
        '{1'b0, 29'h1FFC0000, 1'b1, 3'd5, 4'd3},   // R7 last standard element
        '{1'b0, 29'h04900000, 1'b0, 3'd0, 4'd3},   // R2 unused elements excluded
        '{1'b1, 29'h048C0000, 1'b0, 3'd0, 4'd3},   // R2 standard elements not used
        '{1'b0, 29'h01200000, 1'b0, 3'd0, 4'd3},   // R2 extended elements not used
        '{1'b1, 29'h0ABC0FF,  1'b1, 3'd1, 4'd2}    // R5 lowest of two hits
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input logic [7:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic go_frame(input logic [28:0] id, input logic ide);
        frm_vld = 1'b1; frm_id = id; frm_ide = ide;
        @(negedge clk); #1;
        frm_vld = 1'b0;
        s_cyc = cyc;
    endtask

    task automatic await_n(input int target);
        for (int k = 0; k < 60; k++) begin
            if (n_done >= target) break;
            @(negedge clk); #1;
        end
    endtask

    task automatic run_frame(input logic [28:0] id, input logic ide, input int ea,
                             input int ei, input int el, input string req);
        int base;
        base = n_done;
        go_frame(id, ide);
        await_n(base + 1);
        chk({req, " done"}, int'(n_done > base), 1);
        chk({req, " accept"}, r_acc[base % 8], ea);
        chk({req, " index"}, r_idx[base % 8], ei);
        chk({req, " latency"}, r_cyc[base % 8] - s_cyc, el);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; frm_vld = 1'b0; frm_id = '0; frm_ide = 1'b0;
        wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        #1;
        // R1 reset outputs
        chk("R1 done", int'(dec_done), 0);
        chk("R1 accept", int'(dec_accept), 0);
        chk("R1 index", int'(dec_index), 0);
        rst = 1'b0;
        idle(2);

        // R1 reset counts: one standard element with zero mask; no extended region
        run_frame(29'h155AAAAA & 29'h1FFFFFFF, 1'b0, 1, 0, 1, "R1 default standard");
        run_frame(29'h0000123, 1'b1, 0, 0, 0, "R6 empty extended region");

        // R12 programming
        wr(2'd0, 8'd0, 32'h01234567); wr(2'd1, 8'd0, 32'h1FFFFFFF);
        wr(2'd0, 8'd1, 32'h00ABC000); wr(2'd1, 8'd1, 32'h1FFFF000);
        wr(2'd0, 8'd2, 32'h000000FF); wr(2'd1, 8'd2, 32'h000000FF);
        wr(2'd0, 8'd3, 32'h048C0000); wr(2'd1, 8'd3, 32'h1FFFFFFF);
        wr(2'd0, 8'd4, 32'h10000000); wr(2'd1, 8'd4, 32'h1C000000);
        wr(2'd0, 8'd5, 32'h1FFC0000); wr(2'd1, 8'd5, 32'h1FFC0000);
        wr(2'd2, 8'd0, 32'h03000005);   // NFE=5, NEXIF=3
        idle(1);

        for (int v = 0; v < 11; v++) begin
            run_frame(VECS[v].id, VECS[v].ide, int'(VECS[v].acc), int'(VECS[v].idx),
                      int'(VECS[v].lat), $sformatf("R5 vector %0d", v));
        end

        // R11 clamp: NEXIF=7 > NFE+1=6
        wr(2'd2, 8'd0, 32'h07000005);
        idle(1);
        run_frame(29'h1FFC0000, 1'b0, 0, 0, 0, "R11 standard region empty");
        run_frame(29'h0ABC0FF, 1'b1, 1, 1, 2, "R11 extended hit");
        run_frame(29'h1234566, 1'b1, 0, 0, 6, "R11 six-element reject");
        wr(2'd2, 8'd0, 32'h03000005);
        idle(1);

        // R9 write during scan deferred to the next frame
        base = n_done;
        go_frame(29'h0000001, 1'b1);
        wr_en = 1'b1; wr_kind = 2'd1; wr_idx = 8'd2; wr_data = 32'h0;
        @(negedge clk); #1;
        wr_en = 1'b0;
        await_n(base + 1);
        chk("R9 deferred write not seen", r_acc[base % 8], 0);
        idle(6);
        run_frame(29'h0000001, 1'b1, 1, 2, 3, "R9 deferred write applied");
        wr(2'd1, 8'd2, 32'h000000FF);
        idle(1);

        // R9 queue overflow: three writes during a three-element scan
        base = n_done;
        go_frame(29'h04900000, 1'b0);
        wr_en = 1'b1; wr_kind = 2'd1; wr_idx = 8'd4; wr_data = 32'h0;
        @(negedge clk); #1;
        wr_data = 32'h1C000000;
        @(negedge clk); #1;
        wr_data = 32'h0;
        @(negedge clk); #1;
        wr_en = 1'b0;
        chk("R9 scan result during writes", r_acc[base % 8], 0);
        chk("R7 scan latency during writes", r_cyc[base % 8] - s_cyc, 3);
        idle(8);
        run_frame(29'h04900000, 1'b0, 0, 0, 3, "R9 order kept and excess dropped");

        // R8 one held frame, a third strobe dropped
        base = n_done;
        go_frame(29'h1234566, 1'b1);
        frm_vld = 1'b1; frm_id = 29'h1FFC0000; frm_ide = 1'b0;
        @(negedge clk); #1;
        frm_id = 29'h1234567; frm_ide = 1'b1;
        @(negedge clk); #1;
        frm_vld = 1'b0; frm_id = '0; frm_ide = 1'b1;
        idle(15);
        chk("R8 decision count", n_done - base, 2);
        chk("R8 first reject", r_acc[base % 8], 0);
        chk("R8 held frame accept", r_acc[(base + 1) % 8], 1);
        chk("R8 held frame index", r_idx[(base + 1) % 8], 5);
        chk("R8 held frame timing", r_cyc[(base + 1) % 8] - s_cyc, 7);

        // R12 no-op kind and out-of-range index leave the bank unchanged
        wr(2'd3, 8'd2, 32'h0);
        wr(2'd1, 8'd9, 32'h0);
        idle(1);
        run_frame(29'h0000001, 1'b1, 0, 0, 3, "R12 ignored writes");
        run_frame(29'h048C0000, 1'b0, 1, 3, 1, "R3 standard id, low bits zero");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule